// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block sits on the programmer side of a three-wire serial link (SCK, MOSI, MISO) plus a target reset line. It brings a target microcontroller into serial programming mode. A single `start` pulse begins the session. The block holds SCK at 0 and drives the reset line high for a short, fixed pulse, then holds reset low. It then waits a settling time measured in microseconds of the system clock. After that it shifts the 32-bit enable instruction out on MOSI as the link master, capturing MISO on the same SCK pulses.

The target proves it is in step by sending back the instruction's second byte (0x53) while the third byte is being shifted. When that echo matches, `done` rises and reset stays low so the target remains in programming mode. When it does not match, the block first finishes shifting the whole instruction. It then pulses reset again, waits the settling time again and resends the instruction, counting each retry. After a parameterised number of retries it raises `fail` and stops all link activity.

Top module: `isp_entry_seq`

## Requirements
- R1: After `rst_n` is released, `tgt_rst`, `sck`, `mosi`, `done`, `fail` and `retries` are all 0. SCK is never high while `tgt_rst` is high, and it stays 0 outside instruction shifting.
- R2: A `start` accepted while no session is running drives `tgt_rst` high for exactly RST_PULSE_CYC clock cycles. `tgt_rst` then returns to 0.
- R3: The first SCK rising edge of an attempt comes no sooner than CLK_HZ/1e6*SETTLE_US clock cycles after `tgt_rst` falls.
- R4: Each attempt sends the 32 bits 0xAC, 0x53, 0x00, 0x00, most significant bit first, in SPI mode 0. MOSI is stable at each SCK rising edge, MISO is sampled on the rising edge, and SCK stays high for SCK_DIV clock cycles per pulse.
- R5: All 32 bits are shifted in every attempt, including attempts whose echo turns out to be wrong.
- R6: If the 8 MISO bits sampled at rising edges 16 to 23 of the attempt (counted from 0) equal 0x53, `done` rises and holds. `tgt_rst`, `sck` and `mosi` then stay 0.
- R7: On an echo mismatch with `retries` below MAX_RETRY, `retries` increments by one. A new reset pulse, a new settling wait and a new full instruction then follow.
- R8: On an echo mismatch with `retries` equal to MAX_RETRY, `fail` rises and holds, and `retries` stays at MAX_RETRY. No SCK pulse or reset pulse occurs until the next `start`.
- R9: A `start` while `done` or `fail` is high begins a new session with `retries` cleared to 0.
- R10: A `start` while a session is running (reset pulse, settling wait, shifting or echo check) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| start | input | 1 | Begin a programming-mode entry session |
| miso | input | 1 | Serial data from the target |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| tgt_rst | output | 1 | Target reset line, high means reset pulse, low means programming mode |
| done | output | 1 | Target answered with the correct echo |
| fail | output | 1 | Retries exhausted without a correct echo |
| retries | output | $clog2(MAX_RETRY+1) | Retries performed in the current session |

## Verification
An error in the timer or state register shows up within one attempt. The reset pulse comes out too short or too long, the settling gap shrinks, or an SCK high phase has the wrong width. All of these are measured at the pins in every attempt. A wrong shift or bit count shows as a corrupted or truncated 32-bit word seen by the modelled target. A modelled target that answers badly for a chosen number of attempts exposes a wrong echo decision or a wrong retry limit. Such an error surfaces as a wrong `retries` value, a missing or extra attempt, or the wrong one of `done` and `fail`, once the session ends.

// File: rtl/isp_entry_seq.sv
module isp_entry_seq #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int SETTLE_US     = 20_000,
  parameter int RST_PULSE_CYC = 8,
  parameter int SCK_DIV       = 8,
  parameter int MAX_RETRY     = 8,
  localparam int RW           = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          tgt_rst,
  output logic          done,
  output logic          fail,
  output logic [RW-1:0] retries
);

  localparam int          SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int          TMAX = (SETTLE_CYC > RST_PULSE_CYC)
                                 ? ((SETTLE_CYC > SCK_DIV) ? SETTLE_CYC : SCK_DIV)
                                 : ((RST_PULSE_CYC > SCK_DIV) ? RST_PULSE_CYC : SCK_DIV);
  localparam int          TW = $clog2(TMAX + 1);
  localparam logic [31:0] ENABLE_WORD = 32'hAC53_0000;
  localparam logic [7:0]  SYNC_ECHO   = 8'h53;

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_SETTLE, S_SHIFT, S_CHECK, S_DONE, S_FAIL
  } state_t;

  state_t        st;
  logic [TW-1:0] tmr;
  logic [31:0]   txsh;
  logic [7:0]    rxsh;
  logic [4:0]    bitc;
  logic [RW-1:0] rty;
  logic          sck_q, rst_q;

  wire tmr_zero  = (tmr == '0);
  wire quiescent = (st == S_IDLE) || (st == S_DONE) || (st == S_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tmr   <= '0;
      txsh  <= '0;
      rxsh  <= '0;
      bitc  <= '0;
      rty   <= '0;
      sck_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      case (st)
        S_PULSE: begin
          if (tmr_zero) begin
            rst_q <= 1'b0;
            tmr   <= TW'(SETTLE_CYC - 1);
            st    <= S_SETTLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_SETTLE: begin
          if (tmr_zero) begin
            txsh <= ENABLE_WORD;
            bitc <= '0;
            tmr  <= TW'(SCK_DIV - 1);
            st   <= S_SHIFT;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_SHIFT: begin
          if (!tmr_zero) begin
            tmr <= tmr - 1'b1;
          end else begin
            tmr <= TW'(SCK_DIV - 1);
            if (!sck_q) begin
              sck_q <= 1'b1;
              if (bitc[4:3] == 2'b10) rxsh <= {rxsh[6:0], miso};
            end else begin
              sck_q <= 1'b0;
              txsh  <= {txsh[30:0], 1'b0};
              bitc  <= bitc + 1'b1;
              if (bitc == 5'd31) st <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (rxsh == SYNC_ECHO) begin
            st <= S_DONE;
          end else if (rty == RW'(MAX_RETRY)) begin
            st <= S_FAIL;
          end else begin
            rty   <= rty + 1'b1;
            rst_q <= 1'b1;
            tmr   <= TW'(RST_PULSE_CYC - 1);
            st    <= S_PULSE;
          end
        end
        default: begin
          if (quiescent && start) begin
            rty   <= '0;
            rst_q <= 1'b1;
            tmr   <= TW'(RST_PULSE_CYC - 1);
            st    <= S_PULSE;
          end
        end
      endcase
    end
  end

  assign sck     = sck_q;
  assign mosi    = (st == S_SHIFT) && txsh[31];
  assign tgt_rst = rst_q;
  assign done    = (st == S_DONE);
  assign fail    = (st == S_FAIL);
  assign retries = rty;

endmodule

// File: rtl/isp_entry_seq_chk.sv
module isp_entry_seq_chk #(
  parameter int MAX_RETRY = 8,
  parameter int RW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          sck,
  input logic          mosi,
  input logic          tgt_rst,
  input logic          done,
  input logic          fail,
  input logic [RW-1:0] retries
);

  // R1
  sck_low_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !sck);

  // R6
  done_quiet_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tgt_rst && !sck && !mosi));

  // R8
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(retries) <= MAX_RETRY);

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7
  retry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(retries) |-> ((retries == RW'($past(retries) + 1'b1)) || (retries == '0)));

  // R8
  fail_quiet_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!tgt_rst && !sck && !mosi));

endmodule

bind isp_entry_seq isp_entry_seq_chk #(.MAX_RETRY(MAX_RETRY), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sck(sck), .mosi(mosi),
  .tgt_rst(tgt_rst), .done(done), .fail(fail), .retries(retries)
);

// File: tb/test_isp_entry_seq.sv
module test_isp_entry_seq;
  localparam int CLK_PERIOD    = 10;
  localparam int CLK_HZ        = 1_000_000;
  localparam int SETTLE_US     = 200;
  localparam int RST_PULSE_CYC = 4;
  localparam int SCK_DIV       = 2;
  localparam int MAX_RETRY     = 3;
  localparam int SETTLE_CYC    = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int RW            = $clog2(MAX_RETRY + 1);
  localparam logic [31:0] ENABLE_WORD = 32'hAC53_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic miso, sck, mosi, tgt_rst, done, fail;
  logic [RW-1:0] retries;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_entry_seq #(
    .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .RST_PULSE_CYC(RST_PULSE_CYC),
    .SCK_DIV(SCK_DIV), .MAX_RETRY(MAX_RETRY)
  ) i_isp_entry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .sck(sck),
    .mosi(mosi), .tgt_rst(tgt_rst), .done(done), .fail(fail), .retries(retries)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Target model: echoes what it received 8 bits earlier; corrupts byte 3 on bad attempts.
  logic [31:0] exp_q[$];
  logic [31:0] t_rx = '0;
  int t_bit = 0, t_words = 0, n_bad = 0;
  logic bad_now;

  assign bad_now = (t_words < n_bad) && (t_bit >= 16) && (t_bit < 24);
  assign miso    = (t_bit >= 8) ? (t_rx[7] ^ bad_now) : 1'b0;

  // Scoreboard monitor: pops the expected word whenever 32 bits have arrived.
  always @(posedge sck or posedge tgt_rst) begin
    if (tgt_rst) begin
      t_bit = 0;
    end else begin
      t_rx = {t_rx[30:0], mosi};
      t_bit++;
      if (t_bit == 32) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected extra attempt", t_rx, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(t_rx == e, "R4 instruction word", t_rx, e);
        end
        t_words++;
        t_bit = 0;
      end
    end
  end

  // Pin timing monitor
  int rst_hi = 0, gap = 0, sck_hi = 0;
  bit gap_on = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tgt_rst) rst_hi++;
      else if (rst_hi != 0) begin
        chk(rst_hi == RST_PULSE_CYC, "R2 reset pulse width", rst_hi, RST_PULSE_CYC);
        rst_hi = 0; gap_on = 1; gap = 0;
      end
      if (gap_on) begin
        if (sck) begin
          chk(gap >= SETTLE_CYC, "R3 settle gap", gap, SETTLE_CYC);
          gap_on = 0;
        end else gap++;
      end
      if (sck) sck_hi++;
      else if (sck_hi != 0) begin
        chk(sck_hi == SCK_DIV, "R4 sck high width", sck_hi, SCK_DIV);
        sck_hi = 0;
      end
      if (sck && tgt_rst) chk(1'b0, "R1 sck high during reset", 1, 0);
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Driver: pushes the expected words, runs one session, checks the outcome.
  task automatic session(input int bad, input bit exp_fail, input bit poke);
    int attempts;
    bit quiet;
    attempts = exp_fail ? MAX_RETRY + 1 : bad + 1;
    n_bad = bad;
    t_words = 0;
    for (int i = 0; i < attempts; i++) exp_q.push_back(ENABLE_WORD);
    pulse_start();
    if (poke) begin
      // R10: start mid-shift must not restart the attempt
      wait (sck);
      pulse_start();
    end
    wait (done || fail);
    @(negedge clk);
    chk(done == !exp_fail, "R6 done", done, !exp_fail);
    chk(fail == exp_fail, "R8 fail", fail, exp_fail);
    chk(32'(retries) == (exp_fail ? MAX_RETRY : bad), "R7 retries", retries, exp_fail ? MAX_RETRY : bad);
    chk(t_words == attempts, "R5 attempts fully shifted", t_words, attempts);
    chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
    quiet = 1;
    repeat (300) begin
      @(negedge clk);
      if (sck || tgt_rst || mosi) quiet = 0;
    end
    chk(quiet, exp_fail ? "R8 link idle after fail" : "R6 link idle after done", quiet, 1);
    chk(exp_fail ? fail : done, "R6 R8 outcome held", exp_fail ? fail : done, 1);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({tgt_rst, sck, mosi, done, fail} == 5'b0, "R1 reset outputs", {tgt_rst, sck, mosi, done, fail}, 0);
    chk(retries == '0, "R1 reset retries", retries, 0);
    session(0, 1'b0, 1'b0);
    session(2, 1'b0, 1'b0);
    // R9: restart from done, retries cleared; R10 poke during shifting
    session(0, 1'b0, 1'b1);
    session(9, 1'b1, 1'b0);
    // R9: restart from fail
    session(1, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule